// File: doc/BRIEF.md
# Instruction skip-pattern sequencer

This block sits next to a two-slot fetch/execute pipeline. It owns the fetch address and the execute-slot address. It also owns a skip bitmask, which a skip instruction in the execute slot loads. For each instruction after that skip instruction, the mask decides whether the instruction runs. The sequencer has two modes. In the cancelling mode, a skipped instruction still moves through the execute slot, but it is flagged as cancelled. In the fast mode, the fetch address jumps over each run of skipped instructions, so those instructions are never fetched.

Two other events affect the sequence. The first is interrupt insertion: the interrupt logic takes one slot, and for that slot the sequencer freezes all of its state instead of holding the interrupt back. The second is a return whose target lies in a small reserved address window. Such a return starts a bytecode-dispatch sequence of fixed length. It clears any pattern still in progress, and no interrupt is granted until the dispatch sequence ends. Decode, the bytecode table and flag handling are outside this block.

Top module: `skipseq_top`

## Requirements
- R1: After reset, exec_pc is 0, fetch_pc is 1, and exec_cancel, irq_grant, dispatch_busy and skip_active are all 0.
- R2: Cancelling mode (skip_fast=0). Suppose skip_load is accepted while exec_pc=P with pattern p. Then the instruction at P+1+k enters the execute slot k+1 cycles later, with exec_cancel equal to p[k]. Both addresses step by one each cycle.
- R3: Fast mode, steady state. Each cycle, fetch_pc advances by one plus the number of consecutive 1 bits at the bottom of the remaining pattern. The pattern is consumed by the same amount. exec_cancel stays 0, and no skipped address ever appears on exec_pc.
- R4: Fast-mode load cycle. The instruction already fetched behind the skip instruction (at fetch_pc) enters execute with exec_cancel equal to p[0]. In the same cycle, fetch_pc moves to fetch_pc+1+t, where t is the count of trailing 1 bits of p shifted right by one.
- R5: When no pattern is active (skip_active=0), fetch_pc increments by one and exec_cancel is 0.
- R6: An accepted skip_load while a pattern is active replaces that pattern and its mode with the new ones.
- R7: irq_grant goes high for exactly one cycle. It is set the cycle after a cycle in which all of the following hold: irq_req is 1, irq_grant is 0, dispatch_busy is 0, and no window return is accepted. It is never high two cycles in a row.
- R8: In a cycle where irq_grant is 1, the following are all held: fetch_pc, exec_pc, exec_cancel and the pattern. skip_load and ret_valid are ignored in that cycle. Skipping resumes from the saved position afterwards.
- R9: An accepted return with ret_addr in 0x1F8 to 0x1FF (both included) has these effects. fetch_pc becomes ret_addr. The old fetch_pc enters execute cancelled. skip_active drops to 0 immediately, even if 1 bits remain.
- R10: After an accepted window return, dispatch_busy is 1 for exactly 6 cycles. No grant is issued while dispatch_busy is 1, so the earliest grant comes 8 cycles after the return cycle.
- R11: An accepted return outside the window redirects fetch_pc and cancels the in-flight instruction. The pattern keeps its position. A return takes priority over skip_load in the same cycle.
- R12: When exec_cancel is 1, skip_load and ret_valid from that slot are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| skip_load | input | 1 | Execute slot holds a skip instruction |
| skip_fast | input | 1 | Mode of that skip: 1 fast, 0 cancelling |
| skip_pat | input | W | Skip mask; bit 0 is the next instruction |
| ret_valid | input | 1 | Execute slot holds a return |
| ret_addr | input | AW | Return target address |
| irq_req | input | 1 | Interrupt logic wants a slot |
| fetch_pc | output | AW | Address fetched this cycle |
| exec_pc | output | AW | Address in the execute slot |
| exec_cancel | output | 1 | Execute-slot instruction is cancelled |
| irq_grant | output | 1 | Interrupt call occupies this slot |
| dispatch_busy | output | 1 | Dispatch sequence running |
| skip_active | output | 1 | Unconsumed pattern bits remain |

## Verification
Both modes are driven with the same set of masks. A low run of 1 bits shows whether the first-slot cancel and the first variable jump happen together. All 1s checks a shift of the full width. Alternating bits distinguish single-position jumps from longer ones, and a top-heavy mask shows the return to idle after a long run of zeros. An interrupt request is placed at every cycle offset of a sequence in each mode, which shows whether the freeze keeps the position it saved. Returns to both ends of the window and just outside it check the pattern clear and the dispatch interrupt block. A load arriving on a cancelled slot checks that the slot has no effect.

// File: rtl/skipseq_pkg.sv
package skipseq_pkg;
  typedef enum logic {MODE_CANCEL = 1'b0, MODE_FAST = 1'b1} skip_mode_e;
endpackage

// File: rtl/skipseq_adv.sv
module skipseq_adv #(
  parameter int W  = 32,
  parameter int SW = 6
) (
  input  logic [W-1:0]  src,
  input  logic          fast,
  output logic [SW-1:0] step,
  output logic [W-1:0]  rest
);
  logic [SW-1:0] low_run;

  // count consecutive ones from bit 0
  always_comb begin
    logic run;
    run     = 1'b1;
    low_run = '0;
    for (int i = 0; i < W; i++) begin
      if (run && src[i]) low_run = low_run + 1'b1;
      else               run     = 1'b0;
    end
  end

  always_comb begin
    step = fast ? low_run + 1'b1 : SW'(1);
    rest = (int'(step) >= W) ? '0 : (src >> step);
  end
endmodule

// File: rtl/skipseq_irq.sv
module skipseq_irq #(
  parameter int DISP = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic irq_req,
  input  logic disp_start,
  output logic grant,
  output logic busy
);
  localparam int CW = $clog2(DISP + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      grant <= 1'b0;
    end else begin
      if (disp_start)    cnt <= CW'(DISP);
      else if (cnt != 0) cnt <= cnt - 1'b1;
      grant <= irq_req && !grant && (cnt == 0) && !disp_start;
    end
  end

  assign busy = (cnt != 0);

  a_r7_grant_one_cycle: assert property (@(posedge clk) disable iff (rst)
    grant |=> !grant);
  a_r10_no_grant_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> !grant);
  a_r10_busy_starts: assert property (@(posedge clk) disable iff (rst)
    disp_start |=> busy);
endmodule

// File: rtl/skipseq_top.sv
module skipseq_top
  import skipseq_pkg::*;
#(
  parameter int W         = 32,
  parameter int AW        = 10,
  parameter int RESET_PC  = 0,
  parameter int WIN_BASE  = 'h1F8,
  parameter int WIN_SPAN  = 8,
  parameter int DISP      = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          skip_load,
  input  logic          skip_fast,
  input  logic [W-1:0]  skip_pat,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_addr,
  input  logic          irq_req,
  output logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] exec_pc,
  output logic          exec_cancel,
  output logic          irq_grant,
  output logic          dispatch_busy,
  output logic          skip_active
);
  localparam int SW = $clog2(W + 2);
  localparam logic [AW-1:0] WIN_LO = AW'(WIN_BASE);
  localparam logic [AW-1:0] WIN_HI = AW'(WIN_BASE + WIN_SPAN - 1);

  logic [W-1:0]  pat_q;
  skip_mode_e    mode_q;
  logic          acc_ret, acc_ld, in_win, win_start;
  skip_mode_e    src_mode;
  logic [W-1:0]  src, rest;
  logic [SW-1:0] step;
  logic          cancel_nx;

  always_comb begin
    acc_ret   = ret_valid && !exec_cancel && !irq_grant;
    in_win    = (ret_addr >= WIN_LO) && (ret_addr <= WIN_HI);
    win_start = acc_ret && in_win;
    acc_ld    = skip_load && !exec_cancel && !irq_grant && !ret_valid;
    if (acc_ld) begin
      src_mode  = skip_fast ? MODE_FAST : MODE_CANCEL;
      src       = skip_fast ? (skip_pat >> 1) : skip_pat;
      cancel_nx = skip_pat[0];
    end else begin
      src_mode  = mode_q;
      src       = pat_q;
      cancel_nx = (mode_q == MODE_FAST) ? 1'b0 : pat_q[0];
    end
  end

  skipseq_adv #(.W(W), .SW(SW)) adv_i (
    .src  (src),
    .fast (src_mode == MODE_FAST),
    .step (step),
    .rest (rest)
  );

  skipseq_irq #(.DISP(DISP)) irq_i (
    .clk        (clk),
    .rst        (rst),
    .irq_req    (irq_req),
    .disp_start (win_start),
    .grant      (irq_grant),
    .busy       (dispatch_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc    <= AW'(RESET_PC + 1);
      exec_pc     <= AW'(RESET_PC);
      exec_cancel <= 1'b0;
      pat_q       <= '0;
      mode_q      <= MODE_CANCEL;
    end else if (!irq_grant) begin
      exec_pc <= fetch_pc;
      if (acc_ret) begin
        exec_cancel <= 1'b1;
        fetch_pc    <= ret_addr;
        if (in_win) pat_q <= '0;
      end else begin
        exec_cancel <= cancel_nx;
        fetch_pc    <= fetch_pc + AW'(step);
        pat_q       <= rest;
        if (acc_ld) mode_q <= src_mode;
      end
    end
  end

  assign skip_active = (pat_q != '0);

  a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
    irq_grant |=> $stable(fetch_pc) && $stable(exec_pc) && $stable(exec_cancel));
  a_r9_window_clears: assert property (@(posedge clk) disable iff (rst)
    win_start |=> !skip_active && exec_cancel);
  a_r5_idle_step: assert property (@(posedge clk) disable iff (rst)
    (!skip_active && !irq_grant && !ret_valid && !skip_load)
      |=> (fetch_pc == $past(fetch_pc) + AW'(1)) && !exec_cancel);
  a_r12_cancelled_no_load: assert property (@(posedge clk) disable iff (rst)
    (exec_cancel && !skip_active && !irq_grant) |=> !skip_active);
endmodule

// File: tb/skipseq_top_tb_top.sv
module skipseq_top_tb_top;
  localparam int W = 32;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic skip_load = 0, skip_fast = 0, ret_valid = 0, irq_req = 0;
  logic [W-1:0] skip_pat = '0;
  logic [AW-1:0] ret_addr = '0;
  logic [AW-1:0] fetch_pc, exec_pc;
  logic exec_cancel, irq_grant, dispatch_busy, skip_active;

  int total = 0;
  int bad = 0;

  // reference state
  logic [AW-1:0] m_fetch, m_exec;
  logic m_cancel, m_grant, m_fast;
  logic [W-1:0] m_pat;
  int m_cnt;

  always #2.5 clk = ~clk;

  skipseq_top dut_i (
    .clk(clk), .rst(rst), .skip_load(skip_load), .skip_fast(skip_fast),
    .skip_pat(skip_pat), .ret_valid(ret_valid), .ret_addr(ret_addr),
    .irq_req(irq_req), .fetch_pc(fetch_pc), .exec_pc(exec_pc),
    .exec_cancel(exec_cancel), .irq_grant(irq_grant),
    .dispatch_busy(dispatch_busy), .skip_active(skip_active)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "fetch_pc", int'(fetch_pc), int'(m_fetch));
    chk(tag, "exec_pc", int'(exec_pc), int'(m_exec));
    chk(tag, "exec_cancel", int'(exec_cancel), int'(m_cancel));
    chk(tag, "irq_grant", int'(irq_grant), int'(m_grant));
    chk(tag, "dispatch_busy", int'(dispatch_busy), (m_cnt != 0) ? 1 : 0);
    chk(tag, "skip_active", int'(skip_active), (m_pat != 0) ? 1 : 0);
  endtask

  function automatic int low_ones(input logic [W-1:0] v);
    int n = 0;
    while (n < W && v[n]) n++;
    return n;
  endfunction

  // check present outputs, apply inputs, advance reference by one edge
  task automatic tick(input string tag, input logic ld, input logic fs,
                      input logic [W-1:0] p, input logic rv,
                      input logic [AW-1:0] ra, input logic rq);
    logic acc_r, acc_l, win, ng;
    logic [W-1:0] q;
    int n, nc;
    check_all(tag);
    skip_load = ld; skip_fast = fs; skip_pat = p;
    ret_valid = rv; ret_addr = ra; irq_req = rq;
    win = (ra >= 10'h1F8) && (ra <= 10'h1FF);
    acc_r = 0;
    if (!m_grant) begin
      acc_r = rv && !m_cancel;
      acc_l = ld && !m_cancel && !rv;
      m_exec = m_fetch;
      if (acc_r) begin
        m_cancel = 1;
        m_fetch = ra;
        if (win) m_pat = '0;
      end else if (acc_l) begin
        m_fast = fs;
        m_cancel = p[0];
        if (fs) begin
          q = p >> 1;
          n = low_ones(q);
          m_fetch = m_fetch + AW'(n + 1);
          m_pat = (n + 1 >= W) ? '0 : q >> (n + 1);
        end else begin
          m_fetch = m_fetch + 1'b1;
          m_pat = p >> 1;
        end
      end else if (m_fast) begin
        n = low_ones(m_pat);
        m_cancel = 0;
        m_fetch = m_fetch + AW'(n + 1);
        m_pat = (n + 1 >= W) ? '0 : m_pat >> (n + 1);
      end else begin
        m_cancel = m_pat[0];
        m_fetch = m_fetch + 1'b1;
        m_pat = m_pat >> 1;
      end
    end
    ng = rq && !m_grant && (m_cnt == 0) && !(acc_r && win);
    nc = (acc_r && win) ? 6 : (m_cnt > 0 ? m_cnt - 1 : 0);
    m_grant = ng;
    m_cnt = nc;
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) tick(tag, 0, 0, '0, 0, '0, 0);
  endtask

  task automatic run_pat(input logic fs, input logic [W-1:0] p);
    tick(fs ? "R3" : "R2", 1, fs, p, 0, '0, 0);
    tick(fs ? "R4" : "R2", 0, 0, '0, 0, '0, 0);
    idle(fs ? "R3" : "R2", 34);
    idle("R5", 3);
    chk("R5", "skip_active idle", int'(skip_active), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] pats [6];
    pats[0] = 32'h0000_0007; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h5555_5555;
    pats[3] = 32'hAAAA_AAAA; pats[4] = 32'hE000_0000; pats[5] = 32'h0000_0036;
    m_fetch = 1; m_exec = 0; m_cancel = 0; m_grant = 0; m_fast = 0;
    m_pat = '0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "exec_pc", int'(exec_pc), 0);
    chk("R1", "fetch_pc", int'(fetch_pc), 1);
    chk("R1", "exec_cancel", int'(exec_cancel), 0);
    chk("R1", "irq_grant", int'(irq_grant), 0);
    chk("R1", "dispatch_busy", int'(dispatch_busy), 0);
    chk("R1", "skip_active", int'(skip_active), 0);
    idle("R5", 3);

    // R2 / R3 / R4: mask sweep in both modes
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 6; k++) run_pat(m[0], pats[k]);

    // R4 explicit: fast load with low 1s, cancel + jump together
    tick("R4", 1, 1, 32'h0000_000F, 0, '0, 0);
    chk("R4", "cancel first slot", int'(exec_cancel), 1);
    idle("R3", 6);

    // R6: replace an active plain pattern with a fast one
    tick("R6", 1, 0, 32'h0000_0F00, 0, '0, 0);
    tick("R6", 0, 0, '0, 0, '0, 0);
    tick("R6", 1, 1, 32'h0000_0006, 0, '0, 0);
    idle("R6", 12);

    // R12: load on a cancelled slot is ignored
    tick("R12", 1, 0, 32'h0000_00FF, 0, '0, 0);
    tick("R12", 1, 1, 32'h0000_0000, 0, '0, 0);
    tick("R12", 0, 0, '0, 1, 10'h1FA, 0);
    chk("R12", "skip_active kept", int'(skip_active), 1);
    idle("R12", 12);

    // R7 / R8: interrupt at every offset, both modes
    for (int m = 0; m < 2; m++)
      for (int off = 0; off < 14; off++) begin
        tick("R8", 1, m[0], 32'h0000_36D6, 0, '0, 0);
        idle("R8", off);
        tick("R7", 0, 0, '0, 0, '0, 1);
        tick("R7", 1, 1, 32'h0000_00FF, 1, 10'h1F8, 0);
        idle("R8", 20);
      end
    // R7: held request yields isolated grants
    tick("R7", 0, 0, '0, 0, '0, 1);
    for (int i = 0; i < 6; i++) tick("R7", 0, 0, '0, 0, '0, 1);
    idle("R7", 3);

    // R9 / R10: window returns at both ends
    tick("R9", 1, 0, 32'h0000_FFFE, 0, '0, 0);
    tick("R9", 0, 0, '0, 1, 10'h1FF, 1);
    chk("R9", "skip_active cleared", int'(skip_active), 0);
    chk("R9", "fetch_pc target", int'(fetch_pc), 'h1FF);
    for (int i = 0; i < 10; i++) tick("R10", 0, 0, '0, 0, '0, 1);
    idle("R10", 4);
    tick("R9", 1, 1, 32'h0000_FFFE, 0, '0, 0);
    tick("R9", 0, 0, '0, 1, 10'h1F8, 0);
    chk("R10", "dispatch_busy", int'(dispatch_busy), 1);
    idle("R10", 9);

    // R11: returns just outside the window keep the pattern
    tick("R11", 1, 0, 32'h0000_FFFE, 0, '0, 0);
    tick("R11", 1, 1, 32'h0000_0001, 1, 10'h1F7, 0);
    chk("R11", "skip_active kept", int'(skip_active), 1);
    idle("R11", 3);
    tick("R11", 1, 1, 32'h0000_0FF0, 0, '0, 0);
    tick("R11", 0, 0, '0, 1, 10'h200, 0);
    idle("R11", 16);

    check_all("R5");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule